// File: doc/BRIEF.md
# Prioritized interrupt index controller

This block gathers three hardware event sources into one interrupt line with register access: an oscillator-ready event, a supply-level warning and an analog clock error. Each source has a sticky raw status bit, and an enable mask qualifies the raw bits into a masked status. Software can force bits on through a write-one-to-set register and drop them through a write-one-to-clear register. Software can also read an index register, which reports the highest-priority enabled pending source as a small code.

Reading the index register has a side effect: it clears the pending bit it reports. A service routine can therefore read the index, use the code to select a handler, and move on with no separate clear. A hardware event always beats a clear that targets the same bit in the same cycle, so no event is lost.

The register port is a plain address/strobe bus with no handshake. A write takes effect at the clock edge where `wr_en` is high. Read data is registered and appears in the cycle after `rd_en`. A write and a read may share a cycle. The event inputs are one-cycle pulses, one bit per source.

Top module: `irq_index_ctrl`

Register word addresses: 0 index (read-only), 1 enable mask (read/write), 2 raw status (read-only), 3 masked status (read-only), 4 set (write-only), 5 clear (write-only). Source bit positions are: bit 0 oscillator-ready, bit 1 supply-level, bit 2 analog clock error.

## Requirements
- R1: After reset, the raw status, mask and masked status are all 0. The index reads 0 and `irq` is low.
- R2: An `evt[i]` pulse sets raw status bit i at that clock edge. The bit stays set until it is cleared.
- R3: Mask (address 1) is read/write in bits 2:0. Masked status (address 3) equals raw status AND mask. All bits above bit 2 read as 0 at every address.
- R4: Writing address 4 sets each raw status bit whose data bit is 1. A data bit of 0 has no effect.
- R5: Writing address 5 clears raw bits 0 and 2 where the data bit is 1. Data bit 1 (supply-level) clears nothing.
- R6: Index (address 0) reads 0 when no masked bit is pending. Otherwise it reads the position plus 1 of the highest pending masked bit: 3 for analog error, 2 for supply-level, 1 for oscillator-ready. Raw bits that are masked off are not reported.
- R7: A read of the index clears only the raw bit it reports, at the same edge. It clears nothing when it reports 0.
- R8: An `evt[i]` pulse in the same cycle as a clear write or an index read aimed at bit i leaves bit i set.
- R9: `irq` is high exactly when at least one masked status bit is 1. It is low whenever the mask is 0.
- R10: `rd_data` carries the addressed value in the cycle after `rd_en`. It is 0 for addresses 4, 5 and any unmapped address. It is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| evt | input | 3 | Hardware event pulses, one per source |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle. An event pulse always leaves its raw bit set on the next cycle, even when a clear or index read hits that bit in the same cycle. A zero write to the set register changes nothing. A clear write never drops the supply-level bit. An index read with nothing enabled pending leaves the raw vector untouched. Two more properties also hold on every cycle: read data is zero outside read responses, and `irq` stays low under a zero mask. The priority order of the index code, the clearing of only the reported source, and the exclusion of masked-off sources need specific multi-bit patterns. Those behaviours are shown only by the bench's sequences.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;
  localparam int REG_INDEX  = 0;
  localparam int REG_MASK   = 1;
  localparam int REG_RAW    = 2;
  localparam int REG_MASKED = 3;
  localparam int REG_SET    = 4;
  localparam int REG_CLEAR  = 5;
endpackage

// File: rtl/irq_src_bit.sv
module irq_src_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_evt,
  input  logic set_req,
  input  logic clr_req,
  output logic state
);
  // Event and software set both win over any clear request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 state <= 1'b0;
    else if (hw_evt || set_req) state <= 1'b1;
    else if (clr_req)           state <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] sel
);
  // Scan upward so the highest pending position is the one kept.
  always_comb begin
    idx = '0;
    sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i]) begin
        idx    = IDX_W'(i + 1);
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl #(
  parameter int                 NUM_SRC  = 3,
  parameter int                 ADDR_W   = 4,
  parameter int                 DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] CLR_MASK = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] evt,
  output logic              irq
);
  import irq_idx_pkg::*;

  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] raw_q, mask_q, masked;
  logic [NUM_SRC-1:0] set_vec, clr_vec, idx_sel;
  logic [IDX_W-1:0]   idx_val;
  logic [DATA_W-1:0]  rd_mux;
  logic               idx_rd, wr_mask, wr_set, wr_clr;
  logic               unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:NUM_SRC];

  assign idx_rd  = rd_en && (addr == ADDR_W'(REG_INDEX));
  assign wr_mask = wr_en && (addr == ADDR_W'(REG_MASK));
  assign wr_set  = wr_en && (addr == ADDR_W'(REG_SET));
  assign wr_clr  = wr_en && (addr == ADDR_W'(REG_CLEAR));

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wr_data[NUM_SRC-1:0];
  end

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pend (masked),
    .idx  (idx_val),
    .sel  (idx_sel)
  );

  assign set_vec = wr_set ? wr_data[NUM_SRC-1:0] : '0;
  assign clr_vec = (wr_clr ? (wr_data[NUM_SRC-1:0] & CLR_MASK) : '0)
                 | (idx_rd ? idx_sel : '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_evt  (evt[i]),
      .set_req (set_vec[i]),
      .clr_req (clr_vec[i]),
      .state   (raw_q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(REG_INDEX):  rd_mux = DATA_W'(idx_val);
      ADDR_W'(REG_MASK):   rd_mux = DATA_W'(mask_q);
      ADDR_W'(REG_RAW):    rd_mux = DATA_W'(raw_q);
      ADDR_W'(REG_MASKED): rd_mux = DATA_W'(masked);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/irq_index_ctrl_chk.sv
module irq_index_ctrl_chk #(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [NUM_SRC-1:0] set_bits,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq
);
  import irq_idx_pkg::*;

  // R2 and R8: a pulsed source is set next cycle whatever else happened
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

  a_r4_zero_set_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(REG_SET) && set_bits == '0 && !rd_en && evt == '0)
      |=> $stable(raw_q));

  a_r5_supply_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(REG_CLEAR) && !rd_en && raw_q[1]) |=> raw_q[1]);

  a_r7_idle_index_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(REG_INDEX) && !wr_en && evt == '0 && (raw_q & mask_q) == '0)
      |=> $stable(raw_q));

  a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
endmodule

bind irq_index_ctrl irq_index_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .set_bits (wr_data[NUM_SRC-1:0]),
  .evt      (evt),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/irq_index_ctrl_bench.sv
`timescale 1ns/1ps
module irq_index_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  evt = '0;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_index_ctrl u_irq_index_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .evt(evt), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read", rd_data, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  // one bus cycle; any mix of write, read and event pulses
  task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [31:0] d,
                    input logic [2:0] e, input logic [31:0] exp, input string tag);
    wr_en = w; rd_en = r; addr = a; wr_data = d; evt = e;
    if (r) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    op(1'b1, 1'b0, a, d, 3'b000, 32'h0, "");
  endtask
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    op(1'b0, 1'b1, a, 32'h0, 3'b000, exp, tag);
  endtask
  task automatic pulse(input logic [2:0] e);
    op(1'b0, 1'b0, 4'd0, 32'h0, e, 32'h0, "");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    rd(4'd1, 32'h0, "R1 mask reset");
    rd(4'd2, 32'h0, "R1 raw reset");
    rd(4'd3, 32'h0, "R1 masked reset");
    rd(4'd0, 32'h0, "R1 index reset");
    // R2 event sets raw, R9 masked off so no irq
    pulse(3'b001);
    rd(4'd2, 32'h1, "R2 event sets raw bit0");
    check(irq == 1'b0, "R9 irq low with zero mask", 32'(irq), 32'h0);
    // R3 mask, reserved bits zero
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h7, "R3 mask readback reserved zero");
    rd(4'd3, 32'h1, "R3 masked status");
    check(irq == 1'b1, "R9 irq high with masked bit", 32'(irq), 32'h1);
    // R4 set register
    wr(4'd4, 32'h0);
    rd(4'd2, 32'h1, "R4 zero set no effect");
    wr(4'd4, 32'h6);
    rd(4'd2, 32'h7, "R4 set bits 1 and 2");
    // R6 priority and R7 clear-on-read
    rd(4'd0, 32'h3, "R6 analog error wins");
    rd(4'd2, 32'h3, "R7 index read cleared bit2 only");
    rd(4'd0, 32'h2, "R6 supply next");
    rd(4'd2, 32'h1, "R7 cleared bit1 only");
    rd(4'd0, 32'h1, "R6 oscillator last");
    rd(4'd0, 32'h0, "R6 nothing pending");
    rd(4'd2, 32'h0, "R7 all cleared");
    check(irq == 1'b0, "R9 irq low when nothing pending", 32'(irq), 32'h0);
    // R5 clear register, supply bit not clearable
    wr(4'd4, 32'h7);
    wr(4'd5, 32'h7);
    rd(4'd2, 32'h2, "R5 clear leaves supply bit");
    // R6 masked-off sources are not reported
    wr(4'd1, 32'h1);
    wr(4'd4, 32'h7);
    rd(4'd3, 32'h1, "R3 masked subset");
    rd(4'd0, 32'h1, "R6 masked-off sources ignored");
    rd(4'd2, 32'h6, "R7 read cleared bit0");
    // R8 event beats clear and index read
    wr(4'd1, 32'h7);
    op(1'b1, 1'b0, 4'd5, 32'h4, 3'b100, 32'h0, "");
    rd(4'd2, 32'h6, "R8 event beats clear write");
    op(1'b0, 1'b1, 4'd0, 32'h0, 3'b100, 32'h3, "R8 index during event");
    rd(4'd2, 32'h6, "R8 event beats index read clear");
    // R10 write-only and unmapped addresses read zero
    rd(4'd4, 32'h0, "R10 set address reads zero");
    rd(4'd5, 32'h0, "R10 clear address reads zero");
    rd(4'd15, 32'h0, "R10 unmapped reads zero");
    @(negedge clk);
    check(rd_data == 32'h0, "R10 idle rd_data zero", rd_data, 32'h0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule